// File: doc/BRIEF.md
# Per-Address Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each branch keeps its own record of recent outcomes in a first-level table of history shift registers. The table is direct-mapped by PC and has no tags. The pattern held in the selected register picks a 2-bit saturating counter in a second-level pattern table. The counter's upper bit is the prediction. A branch that repeats a short period, such as a loop exit every fourth pass, therefore gets a counter for each point in its cycle.

A lookup presents a fetch PC with `lookup_valid`. On that clock edge the branch's history register is captured. On the next edge the pattern table is read and the prediction is registered. The answer therefore appears two cycles after the lookup edge. A separate resolve port carries the PC and the real outcome of a finished branch. On that edge the counter chosen by the branch's current history moves toward the outcome, and the outcome is shifted into that branch's history register.

Top module: `pa_branch_predictor`

## Requirements
- R1: While reset is asserted and after it is released, `pred_valid` and `pred_taken` are 0. Reset clears every history register to all zeros and sets every counter to 01, so a lookup on any PC before any resolve predicts not-taken.
- R2: `pred_valid` equals `lookup_valid` as it was sampled two rising edges earlier.
- R3: When `pred_valid` is 1, `pred_taken` equals bit 1 of the counter selected by the history pattern that the looked-up PC's entry held. Counter values 2 and 3 mean taken; values 0 and 1 mean not-taken.
- R4: A taken resolve increments the selected counter, and a counter at 3 stays at 3.
- R5: A not-taken resolve decrements the selected counter, and a counter at 0 stays at 0.
- R6: A resolve shifts the outcome into bit 0 of that branch's history register, with 1 for taken, and drops the oldest bit. The counter it updates is the one chosen by the history held before that shift. Each entry keeps its own history.
- R7: The entry index is PC bits [ALIGN_BITS +: log2(BRANCHES)], 4 bits starting at bit 2 by default. Lower bits are ignored. PCs that agree in these bits share one entry.
- R8: A lookup reads the history table as it was before the edge at which the lookup is presented. It reads the counter table as it was before the following edge. A resolve on either of those edges is not seen by that read.
- R9: When `resolve_valid` is 0, `resolve_pc` and `resolve_taken` change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lookup_valid | input | 1 | A lookup is presented this cycle |
| lookup_pc | input | PC_W | Fetch PC to predict |
| pred_valid | output | 1 | Prediction is valid (two cycles after lookup) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| resolve_valid | input | 1 | A resolved branch is presented |
| resolve_pc | input | PC_W | PC of the resolved branch |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A wrong history bit in one entry sends that branch's next lookup to a different counter. The `pred_taken` value then departs from the reference within two cycles of that lookup. A counter that saturates wrongly, or that moves on a resolve that is not valid, shows only once a lookup selects that counter. Only a counter's upper bit reaches the port, so the bench drives long runs in one direction past saturation. It also trains periodic patterns that make the upper bit depend on every history bit.

// File: rtl/pa_branch_predictor.sv
module pa_branch_predictor #(
  parameter int PC_W       = 32,
  parameter int ALIGN_BITS = 2,
  parameter int BRANCHES   = 16,
  parameter int HIST_LEN   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lookup_valid,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  input  logic            resolve_valid,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken
);
  localparam int IDX_W    = $clog2(BRANCHES);
  localparam int PATTERNS = 1 << HIST_LEN;

  logic [BRANCHES-1:0][HIST_LEN-1:0] hist_tbl;
  logic [PATTERNS-1:0][1:0]          ctr_tbl;

  logic [IDX_W-1:0]    look_idx, res_idx;
  logic [HIST_LEN-1:0] res_hist, look_hist_q;
  logic [1:0]          res_ctr;
  logic                look_vld_q;

  assign look_idx = lookup_pc[ALIGN_BITS +: IDX_W];
  assign res_idx  = resolve_pc[ALIGN_BITS +: IDX_W];
  assign res_hist = hist_tbl[res_idx];
  assign res_ctr  = ctr_tbl[res_hist];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      look_vld_q  <= 1'b0;
      look_hist_q <= '0;
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
    end else begin
      look_vld_q  <= lookup_valid;
      look_hist_q <= hist_tbl[look_idx];
      pred_valid  <= look_vld_q;
      pred_taken  <= ctr_tbl[look_hist_q][1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BRANCHES; i++) hist_tbl[i] <= '0;
      for (int j = 0; j < PATTERNS; j++) ctr_tbl[j] <= 2'b01;
    end else if (resolve_valid) begin
      hist_tbl[res_idx] <= {res_hist[HIST_LEN-2:0], resolve_taken};
      if (resolve_taken && res_ctr != 2'b11)
        ctr_tbl[res_hist] <= res_ctr + 2'b01;
      else if (!resolve_taken && res_ctr != 2'b00)
        ctr_tbl[res_hist] <= res_ctr - 2'b01;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> ##1 pred_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> ##1 !pred_valid);
  a_r4_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && resolve_taken && res_ctr == 2'b11) |=> ctr_tbl[$past(res_hist)] == 2'b11);
  a_r5_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_valid && !resolve_taken && res_ctr == 2'b00) |=> ctr_tbl[$past(res_hist)] == 2'b00);
  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid |=> hist_tbl[$past(res_idx)][0] == $past(resolve_taken));
  a_r9_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_valid |=> ($stable(hist_tbl) && $stable(ctr_tbl)));
endmodule

// File: tb/pa_branch_predictor_bench.sv
module pa_branch_predictor_bench;
  localparam int PC_W = 32, ALIGN = 2, ENT = 16, HL = 4;

  logic clk = 0, rst_n = 0;
  logic lookup_valid = 0, resolve_valid = 0, resolve_taken = 0;
  logic [PC_W-1:0] lookup_pc = '0, resolve_pc = '0;
  logic pred_valid, pred_taken;

  pa_branch_predictor #(.PC_W(PC_W), .ALIGN_BITS(ALIGN), .BRANCHES(ENT), .HIST_LEN(HL)) u_pa_branch_predictor (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .resolve_valid(resolve_valid),
    .resolve_pc(resolve_pc), .resolve_taken(resolve_taken));

  always #4 clk = ~clk;

  int hist_m[ENT];
  int ctr_m[1<<HL];
  int hq_m, vq_m, pv_m, pt_m;
  int vectors = 0, errors = 0, cycles = 0;
  bit checking = 0;
  string cur_req = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (hist_m[i]) hist_m[i] = 0;
      foreach (ctr_m[i]) ctr_m[i] = 1;
      hq_m = 0; vq_m = 0; pv_m = 0; pt_m = 0;
    end else begin
      int li, ri, h;
      li = (lookup_pc >> ALIGN) % ENT;
      ri = (resolve_pc >> ALIGN) % ENT;
      pt_m = (ctr_m[hq_m] >= 2) ? 1 : 0;
      pv_m = vq_m;
      vq_m = lookup_valid ? 1 : 0;
      hq_m = hist_m[li];
      if (resolve_valid) begin
        h = hist_m[ri];
        if (resolve_taken && ctr_m[h] < 3) ctr_m[h]++;
        if (!resolve_taken && ctr_m[h] > 0) ctr_m[h]--;
        hist_m[ri] = ((h << 1) | (resolve_taken ? 1 : 0)) % (1 << HL);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      vectors++;
      if (pred_valid !== pv_m[0] || (pv_m != 0 && pred_taken !== pt_m[0])) begin
        errors++;
        $display("FAIL %s: valid=%0b taken=%0b expected valid=%0d taken=%0d",
                 cur_req, pred_valid, pred_taken, pv_m, pt_m);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic drive(input bit lv, input int lpc, input bit rv, input int rpc, input bit rt);
    @(negedge clk);
    lookup_valid = lv; lookup_pc = lpc;
    resolve_valid = rv; resolve_pc = rpc; resolve_taken = rt;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (pred_valid !== 1'b0 || pred_taken !== 1'b0) begin
      errors++;
      $display("FAIL R1: in reset valid=%0b taken=%0b expected 0 0", pred_valid, pred_taken);
    end
    rst_n = 1;
    checking = 1;
    cur_req = "R1";
    drive(1, 'h100, 0, 0, 0); drive(1, 'h3c, 0, 0, 0); idle(3);

    cur_req = "R2";
    for (int i = 0; i < 12; i++) drive(i % 3 != 0, i * 4, 0, 0, 0);
    idle(3);

    cur_req = "R3";
    for (int k = 0; k < 20; k++)
      for (int p = 0; p < 4; p++) begin
        drive(1, 'h40, 0, 0, 0);
        drive(0, 0, 1, 'h40, p != 3);
      end
    idle(3);

    cur_req = "R4";
    for (int i = 0; i < 12; i++) begin drive(0, 0, 1, 'h20, 1); drive(1, 'h20, 0, 0, 0); end
    idle(3);
    cur_req = "R5";
    for (int i = 0; i < 12; i++) begin drive(0, 0, 1, 'h24, 0); drive(1, 'h24, 0, 0, 0); end
    idle(3);

    cur_req = "R6";
    for (int i = 0; i < 6; i++) begin drive(0, 0, 1, 'h08, i[0]); drive(1, 'h08, 1, 'h0c, 1); end
    drive(1, 'h0c, 0, 0, 0); idle(3);

    cur_req = "R7";
    for (int i = 0; i < 8; i++) begin drive(0, 0, 1, 'h80 + 'h40, 1); drive(1, 'h43, 0, 0, 0); end
    drive(1, 'h1040, 0, 0, 0); idle(3);

    cur_req = "R8";
    for (int i = 0; i < 16; i++) drive(1, 'h10, 1, 'h10, i % 4 != 1);
    idle(3);

    cur_req = "R9";
    for (int i = 0; i < 16; i++) begin drive(0, 0, 0, i * 4, 1); drive(1, i * 4, 0, 'h44, 0); end
    idle(3);

    cur_req = "R6";
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 1), $urandom_range(0, 40) * 4, $urandom_range(0, 1),
            $urandom_range(0, 40) * 4, $urandom_range(0, 3) != 0);
    idle(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule